// File: doc/BRIEF.md
# External Bus Phase Sequencer

This block runs a single access on an external parallel bus as an ordered series of six timed phases, named A to F. An upstream decoder hands it a request carrying the address, a read/write flag, write data and the index of the address window the access falls into. Each window has its own timing word and function word, taken as flat configuration vectors. When the request is accepted, the block latches the words for the selected window and uses them for the whole access.

In phase B the block raises the address latch strobe. In phase E it pulls the read or write strobe low, and it can stretch E until the device signals that it is ready. Phase F is a hold phase whose length is set separately for reads and writes. The data lines can be 8 or 16 bits wide. In multiplexed mode they carry the address during phase B. Read data is taken when phase E ends, and a one-cycle completion pulse follows the last phase.

Top module: `xbus_phase_seq`

## Requirements
- R1: Out of reset, and whenever no access is in progress, `busy`, `rsp_done`, `bus_ale` and `bus_ad_oe` are low, both strobes are high, and `bus_addr` and `bus_ad_out` are zero.
- R2: A request is taken at a clock edge where `req_valid` is high and `busy` is low. `busy` is high from the following cycle through the completion cycle. A request presented while `busy` is high is ignored and does not change the access in flight.
- R3: The timing word fields sit at these bits: A = [1:0], B = [2], C = [4:3], D = [5], E = [10:6], read F = [12:11], write F = [14:13]. A field value of zero for A, C, D or F removes that phase with no idle cycle. B lasts field+1 cycles, and E lasts at least field+1 cycles.
- R4: `bus_ale` is high in exactly the cycles of phase B.
- R5: Phase C lasts 0 to 3 cycles and phase D lasts 0 or 1 cycle, each as programmed.
- R6: In phase E only, `bus_rd_n` is low for a read and `bus_wr_n` is low for a write. The two strobes are never low together.
- R7: Phase F uses the write count for writes and the read count for reads.
- R8: The function word fields are: bit 0 = wait-for-ready enable, bit 1 = ready is synchronous, bits [3:2] = bus type. With the wait enabled and the synchronous setting, E ends at the first edge where the minimum count has elapsed and `bus_ready` is high.
- R9: With the wait enabled and the asynchronous setting, `bus_ready` passes through two flops, so E ends no earlier than two edges after `bus_ready` is first sampled high.
- R10: Bus type bit 0 = 1 selects multiplexed mode. In that mode, phase B drives the low address bits on `bus_ad_out` with `bus_ad_oe` high. In demultiplexed mode the data lines are not driven before phase C. `bus_addr` holds the address in every active phase.
- R11: For a write, `bus_ad_out` carries the write data with `bus_ad_oe` high from phase C through phase F. When bus type bit 1 = 0 (8-bit), only the low byte is carried and the high byte is zero.
- R12: For a read, `bus_ad_in` is captured at the edge that ends phase E, zero-extended from its low byte in 8-bit mode. `rsp_rdata` holds that value until the next read.
- R13: `rsp_done` is a one-cycle pulse that comes one cycle after the last active phase. It rises exactly (A + B + C + D + E + F lengths) edges after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_win | input | WIN_W | Selected window index |
| cfg_timing | input | NUM_WIN*15 | Timing words, window i at [i*15 +: 15] |
| cfg_func | input | NUM_WIN*4 | Function words, window i at [i*4 +: 4] |
| busy | output | 1 | Access in progress |
| bus_addr | output | AW | Address lines |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ad_out | output | DW | Data/address lines, outgoing |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_out |
| bus_ad_in | input | DW | Data lines, incoming |
| bus_ready | input | 1 | Device ready |
| rsp_rdata | output | DW | Captured read data |
| rsp_done | output | 1 | Access complete pulse |

## Verification
The completion pulse is due exactly the sum of the phase lengths after the accepting edge. When the ready wait is active, that sum uses an E end of max(minimum, ready edge) in synchronous mode and max(minimum, ready edge + 2) in asynchronous mode. The bench counts falling edges from the request onward and compares the count at which `rsp_done` appears with that figure plus one. Strobe, latch and data-line values are compared at every falling edge inside the access against the phase the count predicts. Captured read data and the return to idle are checked on the falling edge after the pulse.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int TCFG_W = 15;
  localparam int FCFG_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_A, PH_B, PH_C, PH_D, PH_E, PH_F, PH_DONE
  } phase_t;

  // timing word, lowest field at bit 0
  typedef struct packed {
    logic [1:0] f_wr;
    logic [1:0] f_rd;
    logic [4:0] e;
    logic       d;
    logic [1:0] c;
    logic       b;
    logic [1:0] a;
  } tcfg_t;

  typedef struct packed {
    logic [1:0] btype;   // [0] multiplexed, [1] 16-bit
    logic       rdy_sync;
    logic       rdy_en;
  } fcfg_t;

endpackage

// File: rtl/xbus_cfg_sel.sv
module xbus_cfg_sel
  import xbus_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int WIN_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [WIN_W-1:0]          win,
  input  logic [NUM_WIN*TCFG_W-1:0] cfg_timing,
  input  logic [NUM_WIN*FCFG_W-1:0] cfg_func,
  output tcfg_t                     tcfg_live,
  output tcfg_t                     tcfg_q,
  output fcfg_t                     fcfg_q
);

  tcfg_t t_arr [NUM_WIN];
  fcfg_t f_arr [NUM_WIN];
  fcfg_t fcfg_live;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_unpack
    assign t_arr[g] = tcfg_t'(cfg_timing[g*TCFG_W +: TCFG_W]);
    assign f_arr[g] = fcfg_t'(cfg_func[g*FCFG_W +: FCFG_W]);
  end

  always_comb begin
    tcfg_live = '0;
    fcfg_live = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (win == WIN_W'(i)) begin
        tcfg_live = t_arr[i];
        fcfg_live = f_arr[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcfg_q <= '0;
      fcfg_q <= '0;
    end else if (load) begin
      tcfg_q <= tcfg_live;
      fcfg_q <= fcfg_live;
    end
  end

endmodule

// File: rtl/xbus_ready_sync.sv
module xbus_ready_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_in,
  input  logic sync_mode,
  output logic ready_out
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-2:0], ready_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  // synchronous source is sampled directly, asynchronous through the chain
  assign ready_out = sync_mode ? ready_in : pipe_q[STAGES-1];

endmodule

// File: rtl/xbus_phase_fsm.sv
module xbus_phase_fsm
  import xbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   write,
  input  tcfg_t  tcfg_live,
  input  tcfg_t  tcfg_q,
  input  fcfg_t  fcfg_q,
  input  logic   ready,
  output phase_t phase,
  output logic   e_end
);

  localparam int CW = $bits(tcfg_q.e);

  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   fix_len;
  logic          last;
  logic [1:0]    f_len;

  always_comb begin
    f_len = write ? tcfg_q.f_wr : tcfg_q.f_rd;
    case (ph_q)
      PH_A:    fix_len = (CW+1)'(tcfg_q.a);
      PH_B:    fix_len = (CW+1)'(tcfg_q.b) + (CW+1)'(1);
      PH_C:    fix_len = (CW+1)'(tcfg_q.c);
      PH_D:    fix_len = (CW+1)'(tcfg_q.d);
      PH_F:    fix_len = (CW+1)'(f_len);
      default: fix_len = (CW+1)'(1);
    endcase
    last  = ({1'b0, cnt_q} + (CW+1)'(1)) == fix_len;
    e_end = (ph_q == PH_E) && (cnt_q >= tcfg_q.e) && (!fcfg_q.rdy_en || ready);
  end

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE: if (start) ph_d = (tcfg_live.a != '0) ? PH_A : PH_B;
      PH_A:    if (last) ph_d = PH_B;
      PH_B:    if (last) ph_d = (tcfg_q.c != '0) ? PH_C :
                                (tcfg_q.d != 1'b0) ? PH_D : PH_E;
      PH_C:    if (last) ph_d = (tcfg_q.d != 1'b0) ? PH_D : PH_E;
      PH_D:    if (last) ph_d = PH_E;
      PH_E:    if (e_end) ph_d = (f_len != '0) ? PH_F : PH_DONE;
      PH_F:    if (last) ph_d = PH_DONE;
      default: ph_d = PH_IDLE;
    endcase
    if (ph_d != ph_q)          cnt_d = '0;
    else if (cnt_q == '1)      cnt_d = cnt_q;
    else                       cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase = ph_q;

endmodule

// File: rtl/xbus_phase_seq.sv
module xbus_phase_seq
  import xbus_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [AW-1:0]             req_addr,
  input  logic [DW-1:0]             req_wdata,
  input  logic [WIN_W-1:0]          req_win,
  input  logic [NUM_WIN*15-1:0]     cfg_timing,
  input  logic [NUM_WIN*4-1:0]      cfg_func,
  output logic                      busy,
  output logic [AW-1:0]             bus_addr,
  output logic                      bus_ale,
  output logic                      bus_rd_n,
  output logic                      bus_wr_n,
  output logic [DW-1:0]             bus_ad_out,
  output logic                      bus_ad_oe,
  input  logic [DW-1:0]             bus_ad_in,
  input  logic                      bus_ready,
  output logic [DW-1:0]             rsp_rdata,
  output logic                      rsp_done
);

  localparam int HALF = DW / 2;

  tcfg_t         tcfg_live, tcfg_q;
  fcfg_t         fcfg_q;
  phase_t        phase;
  logic          start, e_end, rdy;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          active, wide, muxed, data_ph;

  function automatic logic [DW-1:0] narrow(input logic [DW-1:0] x, input logic w);
    return w ? x : {{(DW-HALF){1'b0}}, x[HALF-1:0]};
  endfunction

  assign start = req_valid && (phase == PH_IDLE);

  xbus_cfg_sel #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) i_cfg_sel (
    .clk(clk), .rst_n(rst_n), .load(start), .win(req_win),
    .cfg_timing(cfg_timing), .cfg_func(cfg_func),
    .tcfg_live(tcfg_live), .tcfg_q(tcfg_q), .fcfg_q(fcfg_q)
  );

  xbus_ready_sync #(.STAGES(2)) i_ready_sync (
    .clk(clk), .rst_n(rst_n), .ready_in(bus_ready),
    .sync_mode(fcfg_q.rdy_sync), .ready_out(rdy)
  );

  xbus_phase_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .write(wr_q),
    .tcfg_live(tcfg_live), .tcfg_q(tcfg_q), .fcfg_q(fcfg_q),
    .ready(rdy), .phase(phase), .e_end(e_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rdata_q <= '0;
    else if (e_end && !wr_q)   rdata_q <= narrow(bus_ad_in, wide);
  end

  always_comb begin
    active  = (phase != PH_IDLE) && (phase != PH_DONE);
    wide    = fcfg_q.btype[1];
    muxed   = fcfg_q.btype[0];
    data_ph = (phase == PH_C) || (phase == PH_D) || (phase == PH_E) || (phase == PH_F);
    busy     = (phase != PH_IDLE);
    rsp_done = (phase == PH_DONE);
    bus_addr = active ? addr_q : '0;
    bus_ale  = (phase == PH_B);
    bus_rd_n = !((phase == PH_E) && !wr_q);
    bus_wr_n = !((phase == PH_E) && wr_q);
    if ((phase == PH_B) && muxed) begin
      bus_ad_out = narrow(addr_q[DW-1:0], wide);
      bus_ad_oe  = 1'b1;
    end else if (data_ph && wr_q) begin
      bus_ad_out = narrow(wdata_q, wide);
      bus_ad_oe  = 1'b1;
    end else begin
      bus_ad_out = '0;
      bus_ad_oe  = 1'b0;
    end
  end

  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/xbus_phase_seq_chk.sv
module xbus_phase_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic bus_ale,
  input logic bus_rd_n,
  input logic bus_wr_n,
  input logic bus_ad_oe,
  input logic rsp_done
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_ad_oe && bus_rd_n && bus_wr_n && !bus_ale && !rsp_done));

  assert_start_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  assert_release_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !busy);

  assert_ale_not_in_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_rd_n && bus_wr_n));

  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  assert_read_lines_released_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_ad_oe);

  assert_done_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

endmodule

bind xbus_phase_seq xbus_phase_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
  .bus_ad_oe(bus_ad_oe), .rsp_done(rsp_done)
);

// File: tb/test_xbus_phase_seq.sv
module test_xbus_phase_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int AW = 24;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, bus_ad_in = '0;
  logic [1:0] req_win = '0;
  logic [NW*15-1:0] cfg_timing = '0;
  logic [NW*4-1:0] cfg_func = '0;
  logic bus_ready = 1'b0;
  logic busy, bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, rsp_done;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_ad_out, rsp_rdata;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_phase_seq #(.NUM_WIN(NW), .AW(AW), .DW(DW)) i_xbus_phase_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_win(req_win),
    .cfg_timing(cfg_timing), .cfg_func(cfg_func), .busy(busy),
    .bus_addr(bus_addr), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
    .bus_ad_in(bus_ad_in), .bus_ready(bus_ready), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] narrow(input logic [DW-1:0] x, input logic w);
    return w ? x : {8'h00, x[7:0]};
  endfunction

  function automatic int imax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  // one access; rr = falling-edge index at which bus_ready rises
  task automatic run_txn(input int win, input bit wr, input logic [AW-1:0] addr,
                         input logic [DW-1:0] wd, input logic [DW-1:0] rd_in, input int rr);
    logic [14:0] t;
    logic [3:0]  f;
    int a, b, c, d, e, fl, pe, e_fin, len, n, strb, ale_n;
    bit done_seen, wide, muxed, addr_ok, data_ok;
    t = cfg_timing[win*15 +: 15];
    f = cfg_func[win*4 +: 4];
    a = int'(t[1:0]); b = int'(t[2]) + 1; c = int'(t[4:3]); d = int'(t[5]);
    e = int'(t[10:6]) + 1; fl = wr ? int'(t[14:13]) : int'(t[12:11]);
    wide = f[3]; muxed = f[2];
    pe = a + b + c + d;
    e_fin = pe + e;
    if (f[0]) e_fin = f[1] ? imax(e_fin, rr) : imax(e_fin, rr + 2);
    len = e_fin + fl;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    req_win = 2'(win); bus_ad_in = rd_in;
    bus_ready = f[0] ? (rr == 0) : bus_ready;
    n = 0; strb = 0; ale_n = 0; done_seen = 0; addr_ok = 1; data_ok = 1;
    while (!done_seen && n < 150) begin
      @(negedge clk);
      n++;
      if (n == 1) begin          // R2: a second request while busy is ignored
        req_addr = ~addr; req_write = ~wr; req_win = 2'(win + 1);
      end
      if (n == 2) req_valid = 1'b0;
      if (bus_ale) begin
        ale_n++;
        if (muxed && !(bus_ad_oe && bus_ad_out == narrow(addr[DW-1:0], wide))) addr_ok = 0;
        if (!muxed && bus_ad_oe) addr_ok = 0;
      end
      if (!bus_rd_n || !bus_wr_n) begin
        strb++;
        if (wr && bus_rd_n == 1'b0) data_ok = 0;
        if (!wr && bus_wr_n == 1'b0) data_ok = 0;
        if (wr && !(bus_ad_oe && bus_ad_out == narrow(wd, wide))) data_ok = 0;
      end
      if (busy && !rsp_done && bus_addr != addr) addr_ok = 0;
      if (rsp_done) done_seen = 1;
      if (f[0] && n == rr) bus_ready = 1'b1;
    end
    chk(done_seen && n == len + 1, "R13 done latency (R3 R5 R7 R8 R9)", n, len + 1);
    chk(strb == e_fin - pe, "R6 strobe cycles", strb, e_fin - pe);
    chk(ale_n == b, "R4 latch cycles", ale_n, b);
    chk(addr_ok, "R10 address drive", 0, 1);
    chk(data_ok, wr ? "R11 write data drive" : "R6 strobe select", 0, 1);
    @(negedge clk);
    chk(!busy && !rsp_done, "R13 single pulse then idle", {busy, rsp_done}, 0);
    if (!wr) begin
      chk(rsp_rdata == narrow(rd_in, wide), "R12 read capture", rsp_rdata, narrow(rd_in, wide));
      bus_ad_in = ~rd_in;
      @(negedge clk);
      chk(rsp_rdata == narrow(rd_in, wide), "R12 hold after capture", rsp_rdata, narrow(rd_in, wide));
    end
    bus_ready = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_win(input int w, input logic [14:0] t, input logic [3:0] f);
    cfg_timing[w*15 +: 15] = t;
    cfg_func[w*4 +: 4] = f;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !rsp_done && !bus_ale && !bus_ad_oe, "R1 reset control", {busy, rsp_done, bus_ale, bus_ad_oe}, 0);
    chk(bus_rd_n && bus_wr_n, "R1 reset strobes", {bus_rd_n, bus_wr_n}, 3);
    chk(bus_addr == '0 && bus_ad_out == '0, "R1 reset lines", bus_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && bus_rd_n && bus_wr_n, "R1 idle after release", busy, 0);
    // directed: minimum timing, 8-bit demux read
    set_win(0, 15'h0000, 4'b0000);
    run_txn(0, 1'b0, 24'h12_3456, 16'h0, 16'hBEEF, 0);
    // directed: maximum timing, 16-bit mux write, window 3
    set_win(3, 15'h7FFF, 4'b1100);
    run_txn(3, 1'b1, 24'hAB_CDEF, 16'h5A5A, 16'h0, 0);
    // directed: max timing 16 mux read (read F count)
    set_win(2, 15'b01_11_11111_1_11_1_11, 4'b1100);
    run_txn(2, 1'b0, 24'h00_1234, 16'h0, 16'hC3A5, 0);
    // directed: sync ready, late
    set_win(1, {2'd1, 2'd2, 5'd2, 1'b0, 2'd1, 1'b0, 2'd1}, 4'b1011);
    run_txn(1, 1'b0, 24'h00_0F0F, 16'h0, 16'h1357, 20);
    // directed: async ready, late
    set_win(1, {2'd1, 2'd2, 5'd2, 1'b0, 2'd1, 1'b0, 2'd1}, 4'b0101);
    run_txn(1, 1'b1, 24'h00_F0F0, 16'h2468, 16'h0, 20);
    // directed: async ready already high before E
    run_txn(1, 1'b0, 24'h00_0001, 16'h0, 16'h00FF, 0);
    // random
    for (int k = 0; k < 60; k++) begin
      int w, rr;
      logic [3:0] fw;
      w = $urandom_range(0, NW - 1);
      fw = 4'($urandom);
      set_win(w, 15'($urandom), fw);
      rr = fw[0] ? $urandom_range(0, 45) : 0;
      run_txn(w, 1'($urandom), AW'($urandom), DW'($urandom), DW'($urandom), rr);
    end
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    finish_run();
  end

endmodule